// File: doc/BRIEF.md
# Programmable Output Clock Divider

This block makes a general-purpose divided clock from a fast input clock. The divide ratio comes from a 5-bit control field. Software writes this field through a single write strobe. Code N (1 to 31) gives an output period of N input cycles. Code 0 parks the output low.

The output is a registered square wave in the input clock domain. A companion single-cycle enable marks the first cycle of every output period, so downstream logic can use either one.

Reset does not stop the output. While reset is low, the ratio is forced to 16 and the divider keeps counting, so the output keeps toggling. Writes are ignored during reset. On the first edge that samples reset high, the divider restarts at phase zero, which gives every later period a known alignment to reset release. A new code written during normal operation is held until the current period ends, so no shortened or stretched pulse is produced.

Top module: `clkdiv_prog`

## Requirements
- R1: For a code N from 1 to 31, `clk_o` repeats every N input cycles. It is high for the first (N+1)/2 cycles of each period (rounded down) and low for the rest, so code 1 keeps it permanently high.
- R2: While the active code is 0, `clk_o` and `en_o` stay low.
- R3: While `rst_ni` is low, the ratio is forced to 16. The output keeps toggling with a 16-cycle period, 8 cycles high.
- R4: On the first rising clock edge that samples `rst_ni` high after it was low, the period restarts at phase zero. In the following cycle `clk_o` and `en_o` are both high, and a 16-cycle period follows.
- R5: A code written during a period does not alter that period. It takes effect from the first cycle after the period's last cycle.
- R6: After a change from nonzero to 0, the output goes low from the next period boundary. After a write of a nonzero code while idle, a fresh period starts: `clk_o` and `en_o` are high in the second cycle after the strobe is sampled.
- R7: `en_o` is high only in the first cycle of each period, and `clk_o` is high in that cycle. For code 1, `en_o` is high every cycle.
- R8: A write presented while `rst_ni` is low is ignored. After release, the ratio is 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low reset, sampled on `clk_i` |
| wr_en_i | input | 1 | Write strobe for the divide field |
| wr_div_i | input | 5 | Divide code written when `wr_en_i` is high (0 = hold low) |
| clk_o | output | 1 | Divided square-wave output |
| en_o | output | 1 | One-cycle pulse at the start of each output period |

## Verification
Both outputs are registered, so any state change decided at an edge is visible in the cycle that follows it. A write strobe sampled at edge k loads the field at k. From idle, the new period shows at the sample after edge k+1. From a running period, it shows at the sample after the edge that closes the current period. The reset release appears in the sample right after the first edge that sees reset high.

The bench keeps a behavioural phase-and-ratio model that is updated on every rising edge from the same inputs. It compares both outputs at the following falling edge, and the directed timing checks count cycles in the same falling-edge samples.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Width of the programmable divide field
    localparam int unsigned DIV_W = 5;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [DIV_W:0]   div_ext_t;

    // Phase-tracking state of the divider
    typedef struct packed {
        div_t act;      // ratio in force for the running period
        div_t cnt;      // phase within the running period
        logic rst_seen; // reset level seen at the previous edge
    } phase_st_t;

    // Registered output wave
    typedef struct packed {
        logic wave;
        logic pulse;
    } wave_st_t;

    // Number of high cycles for a ratio: half, rounded up
    function automatic div_ext_t high_len(input div_t ratio);
        div_ext_t wide;
        wide = {1'b0, ratio} + div_ext_t'(1);
        return wide >> 1;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
    import clkdiv_pkg::*;
#(
    parameter div_t RESET_CODE = div_t'(16)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_en_i,
    input  div_t wr_div_i,
    output div_t cfg_o
);

    div_t cfg_d;
    div_t cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_ni) begin
            cfg_d = RESET_CODE;
        end else if (wr_en_i) begin
            cfg_d = wr_div_i;
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
#(
    parameter div_t RESET_CODE = div_t'(16)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  div_t cfg_i,
    output div_t act_o,
    output div_t act_nxt_o,
    output div_t cnt_nxt_o
);

    localparam div_t LAST_RST = RESET_CODE - div_t'(1);

    phase_st_t st_d;
    phase_st_t st_q;
    logic      at_end;
    logic      release_evt;

    always_comb begin
        st_d          = st_q;
        st_d.rst_seen = rst_ni;
        release_evt   = rst_ni && !st_q.rst_seen;
        at_end        = (st_q.act == '0) || (st_q.cnt >= (st_q.act - div_t'(1)));

        if (!rst_ni) begin
            // ratio forced, counting continues so the output keeps running
            st_d.act = RESET_CODE;
            if (st_q.cnt >= LAST_RST) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + div_t'(1);
            end
        end else if (release_evt) begin
            st_d.act = cfg_i;
            st_d.cnt = '0;
        end else if (at_end) begin
            st_d.act = cfg_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + div_t'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign act_o     = st_q.act;
    assign act_nxt_o = st_d.act;
    assign cnt_nxt_o = st_d.cnt;

endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave
    import clkdiv_pkg::*;
(
    input  logic clk_i,
    input  div_t act_nxt_i,
    input  div_t cnt_nxt_i,
    output logic wave_o,
    output logic pulse_o
);

    wave_st_t st_d;
    wave_st_t st_q;
    logic     running;

    always_comb begin
        running    = (act_nxt_i != '0);
        st_d.wave  = running && ({1'b0, cnt_nxt_i} < high_len(act_nxt_i));
        st_d.pulse = running && (cnt_nxt_i == '0);
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign wave_o  = st_q.wave;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/clkdiv_prog.sv
module clkdiv_prog
    import clkdiv_pkg::*;
#(
    parameter int unsigned RESET_DIV = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [DIV_W-1:0] wr_div_i,
    output logic             clk_o,
    output logic             en_o
);

    localparam div_t RST_CODE = div_t'(RESET_DIV);

    div_t cfg_q;
    div_t act_ratio;
    div_t act_nxt;
    div_t cnt_nxt;

    clkdiv_cfg_reg #(
        .RESET_CODE (RST_CODE)
    ) i_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_div_i (wr_div_i),
        .cfg_o    (cfg_q)
    );

    clkdiv_phase #(
        .RESET_CODE (RST_CODE)
    ) i_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cfg_i     (cfg_q),
        .act_o     (act_ratio),
        .act_nxt_o (act_nxt),
        .cnt_nxt_o (cnt_nxt)
    );

    clkdiv_wave i_wave (
        .clk_i      (clk_i),
        .act_nxt_i  (act_nxt),
        .cnt_nxt_i  (cnt_nxt),
        .wave_o     (clk_o),
        .pulse_o    (en_o)
    );

endmodule

// File: rtl/clkdiv_prog_chk.sv
module clkdiv_prog_chk
    import clkdiv_pkg::*;
#(
    parameter int unsigned RESET_DIV = 16
) (
    input logic clk_i,
    input logic rst_ni,
    input logic clk_o,
    input logic en_o,
    input div_t act_ratio
);

    logic [5:0] gap_q;
    logic [1:0] rst_en_q;

    // R3: during a held reset, start pulses come every RESET_DIV cycles
    always_ff @(posedge clk_i) begin
        if (!rst_ni && en_o && rst_en_q != 2'd0) begin
            p_reset_period_r3: assert (gap_q == 6'(RESET_DIV));
        end
        if (en_o) begin
            gap_q <= 6'd1;
        end else if (gap_q != 6'h3f) begin
            gap_q <= gap_q + 6'd1;
        end
        if (rst_ni) begin
            rst_en_q <= 2'd0;
        end else if (en_o && rst_en_q != 2'd3) begin
            rst_en_q <= rst_en_q + 2'd1;
        end
    end

    p_zero_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_ratio == '0) |-> (!clk_o && !en_o));

    p_release_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(rst_ni)) |=> (clk_o && en_o));

    p_switch_at_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((act_ratio != $past(act_ratio)) && (act_ratio != '0)) |-> en_o);

    p_en_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |-> clk_o);

    p_single_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_o && (act_ratio > div_t'(1)) && $past(rst_ni)) |=> !en_o);

endmodule

bind clkdiv_prog clkdiv_prog_chk #(
    .RESET_DIV (RESET_DIV)
) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_o     (clk_o),
    .en_o      (en_o),
    .act_ratio (act_ratio)
);

// File: tb/test_clkdiv_prog.sv
`timescale 1ns/1ps
module test_clkdiv_prog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_div = 5'd0;
    logic       clk_o;
    logic       en_o;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R3";

    always #4 clk = ~clk;

    clkdiv_prog i_clkdiv_prog (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .wr_en_i  (wr_en),
        .wr_div_i (wr_div),
        .clk_o    (clk_o),
        .en_o     (en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference: field value, ratio in force, phase index
    int m_field = 16;
    int m_ratio = 16;
    int m_phase = 0;
    bit m_rst_prev = 1'b0;
    bit m_valid = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_field = 16;
            m_ratio = 16;
            m_phase = (m_phase >= 15) ? 0 : m_phase + 1;
        end else begin
            if (!m_rst_prev) begin
                m_valid = 1'b1;
                m_ratio = m_field;
                m_phase = 0;
            end else if (m_ratio == 0 || m_phase + 1 >= m_ratio) begin
                m_ratio = m_field;
                m_phase = 0;
            end else begin
                m_phase++;
            end
            if (wr_en) m_field = wr_div;
        end
        m_rst_prev = rst_n;
        if (cyc >= 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (m_valid) begin
            bit e_wave;
            bit e_pulse;
            e_wave  = (m_ratio != 0) && (2 * m_phase < m_ratio);
            e_pulse = (m_ratio != 0) && (m_phase == 0);
            chk(clk_o == e_wave, {cur_req, " clk_o vs model"}, int'(clk_o), int'(e_wave));
            chk(en_o == e_pulse, {cur_req, " en_o vs model"}, int'(en_o), int'(e_pulse));
        end
    end

    task automatic measure(output int per, output int hi);
        int guard = 0;
        while (!en_o && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        per = 0;
        hi = 0;
        do begin
            per++;
            hi += int'(clk_o);
            @(negedge clk);
        end while (!en_o && per < 100);
    endtask

    task automatic write_div(input logic [4:0] v);
        wr_en = 1'b1;
        wr_div = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int per;
        int hi;
        @(negedge clk);
        // R3: output runs at ratio 16 while held in reset
        wait_cyc(80);
        measure(per, hi);
        chk(per == 16, "R3 reset period", per, 16);
        chk(hi == 8, "R3 reset high time", hi, 8);

        // R8: write during reset is ignored
        write_div(5'd5);
        wait_cyc(3);
        rst_n = 1'b1;
        cur_req = "R4";
        @(negedge clk);
        chk(clk_o == 1'b1, "R4 clk_o after release", int'(clk_o), 1);
        chk(en_o == 1'b1, "R4 en_o after release", int'(en_o), 1);
        measure(per, hi);
        chk(per == 16, "R8 period after release", per, 16);
        chk(hi == 8, "R4 high time after release", hi, 8);

        // R1 and R7: every ratio
        cur_req = "R1";
        for (int n = 1; n <= 31; n++) begin
            write_div(5'(n));
            wait_cyc(70);
            measure(per, hi);
            chk(per == n, "R1 period", per, n);
            chk(hi == (n + 1) / 2, "R1 high time", hi, (n + 1) / 2);
            if (n == 1) begin
                chk(en_o && clk_o, "R7 ratio one pulse", int'(en_o), 1);
            end else begin
                @(negedge clk);
                chk(!en_o, "R7 single pulse", int'(en_o), 0);
            end
        end

        // R5: mid-period write does not change the running period
        cur_req = "R5";
        write_div(5'd9);
        wait_cyc(40);
        while (!en_o) @(negedge clk);
        per = 1;
        @(negedge clk);
        per++;
        write_div(5'd3);
        per++;
        while (!en_o && per < 100) begin
            @(negedge clk);
            if (!en_o) per++;
        end
        chk(per == 9, "R5 running period kept", per, 9);
        measure(per, hi);
        chk(per == 3, "R5 new ratio", per, 3);

        // R2: zero code holds low
        cur_req = "R2";
        write_div(5'd0);
        wait_cyc(40);
        hi = 0;
        for (int i = 0; i < 50; i++) begin
            hi += int'(clk_o) + int'(en_o);
            @(negedge clk);
        end
        chk(hi == 0, "R2 output held low", hi, 0);

        // R6: leaving idle starts a fresh period
        cur_req = "R6";
        wr_en = 1'b1;
        wr_div = 5'd7;
        @(negedge clk);
        wr_en = 1'b0;
        chk(clk_o == 1'b0, "R6 still low one cycle after strobe", int'(clk_o), 0);
        @(negedge clk);
        chk(clk_o && en_o, "R6 fresh period start", int'(clk_o && en_o), 1);
        measure(per, hi);
        chk(per == 7, "R6 new period", per, 7);
        // nonzero to zero: model compare tagged R6
        @(negedge clk);
        write_div(5'd0);
        wait_cyc(10);
        chk(!clk_o && !en_o, "R6 low after boundary", int'(clk_o), 0);

        // R3/R4: reset mid-run
        write_div(5'd7);
        wait_cyc(20);
        cur_req = "R3";
        rst_n = 1'b0;
        wait_cyc(60);
        measure(per, hi);
        chk(per == 16, "R3 mid-run reset period", per, 16);
        wait_cyc(5);
        rst_n = 1'b1;
        cur_req = "R4";
        @(negedge clk);
        chk(clk_o && en_o, "R4 realigned on release", int'(clk_o && en_o), 1);
        wait_cyc(40);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule